// File: doc/BRIEF.md
# Sector error statistics accumulator

After a NAND page has been decoded, the error-correction engine leaves one corrected-bit count per sector. These counts sit packed in a small bank of 32-bit words, with four sectors to a word. This block walks that bank one sector per clock and reduces the counts to three page-level figures:

- the total number of corrected bits;
- the number of sectors that could not be corrected;
- the largest number of bit flips found in any single correctable sector.

A count field with every bit set is a sentinel for an uncorrectable sector. The block counts such a sector as failed and leaves it out of both the total and the maximum.

A controller places the word bank on `count_words_i`, gives the number of sectors to scan, and pulses `start_i`. One clock after the last sector has been folded in, `done_o` pulses for a single cycle. The three results then stay valid until the next scan is accepted. The word bank must be held steady while a scan runs.

Top module: `secstat_scan`

## Requirements
- R1: Sector i is taken from word i/4 of `count_words_i` (word k occupies bits [32k+31:32k]), lane i mod 4, and its count field is bits [8*lane+6 : 8*lane] of that word. Bit 7 of each lane is not part of the field.
- R2: A field equal to 7'h7F increments `failed_o` by one and changes neither `corrected_o` nor `bitflips_o`.
- R3: Every field other than 7'h7F is added to `corrected_o`.
- R4: `bitflips_o` is the largest field among the correctable sectors of the scan, and 0 if there are none.
- R5: After reset all outputs are 0. The clock edge that accepts a start clears all three results, and from the next edge on one sector is processed per edge.
- R6: With N sectors, `done_o` is high for exactly one cycle, after the (N+1)-th rising edge counting the accepting edge as the first. The results are held unchanged from then until the next accepted start.
- R7: A `start_i` pulse that arrives while a scan is running has no effect on that scan's timing or results.
- R8: A start with a sector count of 0 or above 16 is ignored: no scan, no `done_o`, and the results stay unchanged.
- R9: `corrected_o` (11 bits) and `failed_o` (5 bits) hold the largest possible values without wrapping. Those values are 16 sectors of 126 bits each (2016) and 16 failed sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle and the count is valid |
| sec_count_i | input | 5 | Number of sectors to scan, 1 to 16 |
| count_words_i | input | 128 | Four packed count words, word 0 in the low bits |
| done_o | output | 1 | One-cycle pulse after the last sector |
| corrected_o | output | 11 | Sum of corrected bits over correctable sectors |
| failed_o | output | 5 | Number of uncorrectable sectors |
| bitflips_o | output | 7 | Largest count in any correctable sector |

## Verification
For a scan of N sectors, all three results and `done_o` are due together, N+1 edges after the edge that accepts the start. The results then hold until the next accepted start. The bench drives and samples on falling edges and counts the edges itself. It checks that `done_o` is still low one sample before it is due, high with the expected results exactly when due, and low again one sample later with the results unchanged. For ignored starts it watches several cycles for a stray `done_o` or any change in the results.

// File: rtl/secstat_pkg.sv
`timescale 1ns/1ps
package secstat_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic {ST_IDLE, ST_SCAN} scan_st_e;

  // Move the selected lane down to bit 0.
  function automatic logic [WORD_W-1:0] lane_bits(input logic [WORD_W-1:0] w,
                                                  input int unsigned lane,
                                                  input int unsigned step);
    return w >> (lane * step);
  endfunction

  // All-ones field of the given width marks an uncorrectable sector.
  function automatic logic field_is_sentinel(input logic [WORD_W-1:0] f,
                                             input int unsigned fw);
    return f == ((WORD_W'(1) << fw) - WORD_W'(1));
  endfunction

  function automatic logic [WORD_W-1:0] max_of(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/secstat_seq.sv
`timescale 1ns/1ps
module secstat_seq
  import secstat_pkg::*;
#(
  parameter int unsigned SECTORS_MAX = 16,
  localparam int unsigned SEC_W = $clog2(SECTORS_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEC_W-1:0] sec_count_i,
  output logic             busy_o,
  output logic             accept_o,
  output logic             cnt_ok_o,
  output logic             last_o,
  output logic             done_o,
  output logic [SEC_W-1:0] idx_o
);
  scan_st_e         state_q;
  logic [SEC_W-1:0] idx_q;
  logic [SEC_W-1:0] last_idx_q;
  logic             done_q;

  assign cnt_ok_o = (sec_count_i != '0) && (sec_count_i <= SEC_W'(SECTORS_MAX));
  assign busy_o   = (state_q == ST_SCAN);
  assign accept_o = start_i && !busy_o && cnt_ok_o;
  assign last_o   = busy_o && (idx_q == last_idx_q);
  assign idx_o    = idx_q;
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      last_idx_q <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        state_q    <= ST_SCAN;
        idx_q      <= '0;
        last_idx_q <= sec_count_i - SEC_W'(1);
      end else if (busy_o) begin
        if (last_o) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + SEC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/secstat_word_pick.sv
`timescale 1ns/1ps
module secstat_word_pick
  import secstat_pkg::*;
#(
  parameter int unsigned SECTORS_MAX = 16,
  parameter int unsigned LANES       = 4,
  localparam int unsigned SEC_W  = $clog2(SECTORS_MAX + 1),
  localparam int unsigned WORDS  = (SECTORS_MAX + LANES - 1) / LANES,
  localparam int unsigned WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [WORDS*WORD_W-1:0] words_i,
  input  logic [SEC_W-1:0]        idx_i,
  output logic [WORD_W-1:0]       word_o,
  output logic [LANE_W-1:0]       lane_o
);
  logic [WORD_W-1:0] word_arr [WORDS];
  logic [WSEL_W-1:0] word_sel;

  for (genvar g = 0; g < WORDS; g++) begin : g_unpack
    assign word_arr[g] = words_i[g*WORD_W +: WORD_W];
  end

  assign word_sel = WSEL_W'(idx_i / SEC_W'(LANES));
  assign lane_o   = LANE_W'(idx_i % SEC_W'(LANES));
  assign word_o   = word_arr[word_sel];
endmodule

// File: rtl/secstat_field.sv
`timescale 1ns/1ps
module secstat_field
  import secstat_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned LANE_SHIFT = 8,
  parameter int unsigned FIELD_W    = 7,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic [LANE_W-1:0]  lane_i,
  output logic [FIELD_W-1:0] field_o,
  output logic               fail_o,
  output logic [FIELD_W-1:0] good_o
);
  assign field_o = FIELD_W'(lane_bits(word_i, 32'(lane_i), LANE_SHIFT));
  assign fail_o  = field_is_sentinel(WORD_W'(field_o), FIELD_W);
  assign good_o  = fail_o ? '0 : field_o;
endmodule

// File: rtl/secstat_accum.sv
`timescale 1ns/1ps
module secstat_accum
  import secstat_pkg::*;
#(
  parameter int unsigned SECTORS_MAX = 16,
  parameter int unsigned FIELD_W     = 7,
  localparam int unsigned SEC_W = $clog2(SECTORS_MAX + 1),
  localparam int unsigned TOT_W = $clog2(SECTORS_MAX * ((2 ** FIELD_W) - 2) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               step_i,
  input  logic               fail_i,
  input  logic [FIELD_W-1:0] val_i,
  output logic [TOT_W-1:0]   total_o,
  output logic [SEC_W-1:0]   fails_o,
  output logic [FIELD_W-1:0] peak_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_o <= '0;
      fails_o <= '0;
      peak_o  <= '0;
    end else if (clear_i) begin
      total_o <= '0;
      fails_o <= '0;
      peak_o  <= '0;
    end else if (step_i) begin
      if (fail_i) begin
        fails_o <= fails_o + SEC_W'(1);
      end else begin
        total_o <= total_o + TOT_W'(val_i);
        peak_o  <= FIELD_W'(max_of(WORD_W'(peak_o), WORD_W'(val_i)));
      end
    end
  end
endmodule

// File: rtl/secstat_scan.sv
`timescale 1ns/1ps
module secstat_scan
  import secstat_pkg::*;
#(
  parameter int unsigned SECTORS_MAX = 16,
  parameter int unsigned LANES       = 4,
  parameter int unsigned LANE_SHIFT  = 8,
  parameter int unsigned FIELD_W     = 7,
  localparam int unsigned SEC_W  = $clog2(SECTORS_MAX + 1),
  localparam int unsigned WORDS  = (SECTORS_MAX + LANES - 1) / LANES,
  localparam int unsigned TOT_W  = $clog2(SECTORS_MAX * ((2 ** FIELD_W) - 2) + 1),
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [SEC_W-1:0]        sec_count_i,
  input  logic [WORDS*WORD_W-1:0] count_words_i,
  output logic                    done_o,
  output logic [TOT_W-1:0]        corrected_o,
  output logic [SEC_W-1:0]        failed_o,
  output logic [FIELD_W-1:0]      bitflips_o
);
  // Named internal events, also observed by the bound checker.
  logic               busy;
  logic               accept;
  logic               cnt_ok;
  logic               last_step;
  logic [SEC_W-1:0]   sec_idx;
  logic [WORD_W-1:0]  cur_word;
  logic [LANE_W-1:0]  cur_lane;
  logic [FIELD_W-1:0] cur_field;
  logic               step_fail;
  logic [FIELD_W-1:0] step_val;

  secstat_seq #(.SECTORS_MAX(SECTORS_MAX)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .sec_count_i(sec_count_i),
    .busy_o     (busy),
    .accept_o   (accept),
    .cnt_ok_o   (cnt_ok),
    .last_o     (last_step),
    .done_o     (done_o),
    .idx_o      (sec_idx)
  );

  secstat_word_pick #(.SECTORS_MAX(SECTORS_MAX), .LANES(LANES)) u_pick (
    .words_i(count_words_i),
    .idx_i  (sec_idx),
    .word_o (cur_word),
    .lane_o (cur_lane)
  );

  secstat_field #(.LANES(LANES), .LANE_SHIFT(LANE_SHIFT), .FIELD_W(FIELD_W)) u_field (
    .word_i (cur_word),
    .lane_i (cur_lane),
    .field_o(cur_field),
    .fail_o (step_fail),
    .good_o (step_val)
  );

  secstat_accum #(.SECTORS_MAX(SECTORS_MAX), .FIELD_W(FIELD_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(accept),
    .step_i (busy),
    .fail_i (step_fail),
    .val_i  (step_val),
    .total_o(corrected_o),
    .fails_o(failed_o),
    .peak_o (bitflips_o)
  );
endmodule

// File: rtl/secstat_scan_chk.sv
`timescale 1ns/1ps
module secstat_scan_chk #(
  parameter int unsigned SECTORS_MAX = 16,
  parameter int unsigned FIELD_W     = 7,
  parameter int unsigned SEC_W       = 5,
  parameter int unsigned TOT_W       = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               accept,
  input logic               start_i,
  input logic               cnt_ok,
  input logic               last_step,
  input logic               step_fail,
  input logic [SEC_W-1:0]   sec_idx,
  input logic               done_o,
  input logic [TOT_W-1:0]   corrected_o,
  input logic [SEC_W-1:0]   failed_o,
  input logic [FIELD_W-1:0] bitflips_o
);
  localparam logic [FIELD_W-1:0] MASK = '1;

  a_r2_fail_only_counts: assert property (@(posedge clk) disable iff (!rst_n)
    busy && step_fail |=> $stable(corrected_o) && $stable(bitflips_o)
                          && failed_o == $past(failed_o) + SEC_W'(1));

  a_r4_peak_not_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
    bitflips_o != MASK);

  a_r5_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && sec_idx == '0 && corrected_o == '0
               && failed_o == '0 && bitflips_o == '0);

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done_o && !busy);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !accept |=> $stable(corrected_o) && $stable(failed_o) && $stable(bitflips_o));

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_step |=> busy && sec_idx == $past(sec_idx) + SEC_W'(1));

  a_r8_bad_count_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy && !cnt_ok |=> !busy && !done_o);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    failed_o <= SEC_W'(SECTORS_MAX)
    && corrected_o <= TOT_W'(SECTORS_MAX * ((2 ** FIELD_W) - 2)));
endmodule

bind secstat_scan secstat_scan_chk #(
  .SECTORS_MAX(SECTORS_MAX),
  .FIELD_W    (FIELD_W),
  .SEC_W      (SEC_W),
  .TOT_W      (TOT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .accept     (accept),
  .start_i    (start_i),
  .cnt_ok     (cnt_ok),
  .last_step  (last_step),
  .step_fail  (step_fail),
  .sec_idx    (sec_idx),
  .done_o     (done_o),
  .corrected_o(corrected_o),
  .failed_o   (failed_o),
  .bitflips_o (bitflips_o)
);

// File: tb/secstat_scan_bench.sv
`timescale 1ns/1ps
module secstat_scan_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [4:0]   sec_count_i = '0;
  logic [127:0] count_words_i = '0;
  logic         done_o;
  logic [10:0]  corrected_o;
  logic [4:0]   failed_o;
  logic [6:0]   bitflips_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  secstat_scan u_secstat_scan (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .sec_count_i  (sec_count_i),
    .count_words_i(count_words_i),
    .done_o       (done_o),
    .corrected_o  (corrected_o),
    .failed_o     (failed_o),
    .bitflips_o   (bitflips_o)
  );

  typedef struct packed {
    logic [127:0] words;   // {word3, word2, word1, word0}
    logic [4:0]   cnt;
    logic [10:0]  sum;
    logic [4:0]   nfail;
    logic [6:0]   peak;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{128'h0, 5'd16, 11'd0, 5'd0, 7'd0},
    '{{96'h0, 32'h04030201}, 5'd4, 11'd10, 5'd0, 7'd4},
    '{{96'h0, 32'h04030201}, 5'd2, 11'd3, 5'd0, 7'd2},
    '{{96'h0, 32'h057F0A7F}, 5'd4, 11'd15, 5'd2, 7'd10},
    '{{96'h0, 32'h80808080}, 5'd4, 11'd0, 5'd0, 7'd0},
    '{{96'h0, 32'hFFFFFF81}, 5'd4, 11'd1, 5'd3, 7'd1},
    '{{4{32'h7E7E7E7E}}, 5'd16, 11'd2016, 5'd0, 7'd126},
    '{{4{32'h7F7F7F7F}}, 5'd16, 11'd0, 5'd16, 7'd0},
    '{{64'h0, 32'h00002230, 32'h01010101}, 5'd5, 11'd52, 5'd0, 7'd48},
    '{{32'h00004009, 32'h7F000000, 64'h0}, 5'd13, 11'd9, 5'd1, 7'd9},
    '{{64'h0, 32'h7F7F0101, 32'h103C027F}, 5'd8, 11'd80, 5'd3, 7'd60}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Issue a start and check the complete result timing for n sectors.
  task automatic run_scan(input logic [127:0] w, input int n, input int e_sum,
                          input int e_fail, input int e_peak);
    @(negedge clk);
    count_words_i = w;
    sec_count_i   = 5'(n);
    start_i       = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (n - 1) @(negedge clk);
    chk("R6 done not early", int'(done_o), 0);
    @(negedge clk);
    chk("R6 done due", int'(done_o), 1);
    chk("R1 R3 corrected total", int'(corrected_o), e_sum);
    chk("R1 R2 failed count", int'(failed_o), e_fail);
    chk("R1 R4 peak bitflips", int'(bitflips_o), e_peak);
    @(negedge clk);
    chk("R6 done single cycle", int'(done_o), 0);
    chk("R6 total held", int'(corrected_o), e_sum);
    chk("R6 failed held", int'(failed_o), e_fail);
    chk("R6 peak held", int'(bitflips_o), e_peak);
  endtask

  // Pulse a start with an invalid count and watch for any reaction.
  task automatic bad_start(input int n, input int e_sum, input int e_fail, input int e_peak);
    int seen_done;
    @(negedge clk);
    sec_count_i = 5'(n);
    start_i     = 1'b1;
    @(negedge clk);
    start_i   = 1'b0;
    seen_done = 0;
    for (int k = 0; k < 20; k++) begin
      if (done_o) seen_done = 1;
      @(negedge clk);
    end
    chk("R8 no done on bad count", seen_done, 0);
    chk("R8 total unchanged", int'(corrected_o), e_sum);
    chk("R8 failed unchanged", int'(failed_o), e_fail);
    chk("R8 peak unchanged", int'(bitflips_o), e_peak);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    chk("R5 reset done", int'(done_o), 0);
    chk("R5 reset total", int'(corrected_o), 0);
    chk("R5 reset failed", int'(failed_o), 0);
    chk("R5 reset peak", int'(bitflips_o), 0);

    for (int i = 0; i < NV; i++)
      run_scan(VECS[i].words, int'(VECS[i].cnt), int'(VECS[i].sum),
               int'(VECS[i].nfail), int'(VECS[i].peak));

    // R5: a scan after a nonzero one starts from cleared results
    run_scan({96'h0, 32'h7F000003}, 1, 3, 0, 3);

    // R7: second start mid-scan with a larger count is ignored
    @(negedge clk);
    count_words_i = {96'h0, 32'h04030201};
    sec_count_i   = 5'd4;
    start_i       = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    sec_count_i = 5'd16;
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R7 done not early", int'(done_o), 0);
    @(negedge clk);
    chk("R7 done at original time", int'(done_o), 1);
    chk("R7 total from first scan", int'(corrected_o), 10);
    chk("R7 peak from first scan", int'(bitflips_o), 4);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (done_o) extra = 1;
      end
      chk("R7 no second done", extra, 0);
    end

    // R8: invalid counts
    bad_start(0, 10, 0, 4);
    count_words_i = {4{32'h7F7F7F7F}};
    bad_start(17, 10, 0, 4);

    finish_run();
  end
endmodule